// File: doc/BRIEF.md
# Calibration Queue Slot Scheduler

This block sequences a single-entry input sample-and-hold queue in front of a converter that runs faster than the input sampling rate. Input sample strobes mark the moments when the queue grabs a new analog sample. Convert-slot strobes mark the moments when the converter is ready to start a conversion. At every slot the scheduler decides on its own whether the converter takes the held sample or spends that slot on the calibration signal. A calibration slot is chosen whenever the queue is empty, so idle converter capacity is spent on calibration while the input stream still looks uniformly sampled.

Each issued slot is tagged, and the tag travels down a fixed-latency pipeline that matches the converter's conversion delay. When the converter result comes back, the block steers it to either the input-data output or the calibration output, each with its own valid strobe. A foreground request turns every slot into a calibration slot. This covers the case where the two rates are equal and calibration has to interrupt the input. A sticky error flags any input sample that arrives while the queue is still occupied, because that sample is lost.

Top module: `cal_queue_sched`

## Requirements
- R1: After reset, `q_full`, `err_overrun`, `dat_valid` and `cal_valid` are all 0, and `dat_out` and `cal_out` are 0.
- R2: In a cycle where `slot_stb` is high, `fg_req` is low and the queue is full, `slot_take` is 1 and `slot_cal` is 0 in that same cycle. If no sample is captured in that cycle, `q_full` reads 0 in the next cycle.
- R3: In a cycle where `slot_stb` is high and either the queue is empty or `fg_req` is high, `slot_cal` is 1 and `slot_take` is 0. With `slot_stb` low, both are 0.
- R4: A sample strobe with `fg_req` low is captured when the queue is empty, or when the held sample is taken in that same cycle. `q_full` reads 1 in the following cycle.
- R5: A sample strobe with `fg_req` low, arriving while the queue is full and not being taken, is dropped. The queue keeps its old sample, and `err_overrun` rises in the next cycle and stays 1 until reset.
- R6: While `fg_req` is high, no slot takes the queue, the queue is emptied (`q_full` reads 0 in the next cycle), and sample strobes are ignored without raising `err_overrun`.
- R7: A slot issued in cycle c produces exactly one result pulse in cycle c+LAT. For a take slot it is a `dat_valid` pulse with `dat_out` = `res_in`. For a calibration slot it is a `cal_valid` pulse with `cal_out` = `res_in`. Whenever its valid is low, each output bus reads 0.
- R8: With slots arriving 1.5 or 2 times as often as samples, no overrun occurs. After draining, the number of data results equals the number of samples, and the number of calibration results equals slots minus samples.
- R9: With equal rates and coincident strobes, the first slot after an empty queue is a calibration slot and every following slot takes a sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| samp_stb | input | 1 | Queue captures an input sample this cycle |
| slot_stb | input | 1 | Converter starts a conversion this cycle |
| fg_req | input | 1 | Foreground calibration: every slot is calibration |
| res_in | input | DW | Converter result for the slot issued LAT cycles earlier |
| slot_take | output | 1 | This slot converts the held input sample |
| slot_cal | output | 1 | This slot converts the calibration signal |
| q_full | output | 1 | Queue holds a sample |
| err_overrun | output | 1 | Sticky: an input sample was dropped |
| dat_valid | output | 1 | Input-data result present |
| dat_out | output | DW | Input-data result |
| cal_valid | output | 1 | Calibration result present |
| cal_out | output | DW | Calibration result |

## Verification
The slot decision is combinational, so `slot_take` and `slot_cal` are compared in the very cycle the slot strobe is driven, one nanosecond after the inputs change. Queue occupancy and the overrun flag are registered, so they are compared in the cycle after the strobe that changed them. Result strobes are due exactly LAT cycles after their slot. To check this, the bench records the kind of each slot it issues in a cycle-indexed history and compares the outputs of cycle c with the entry for cycle c−LAT. Rate-ratio sweeps at 2, 1.5 and 1 (with a foreground window) then compare total data and calibration result counts against numbers derived from the strobe patterns.

// File: rtl/cqs_pkg.sv
package cqs_pkg;

  typedef enum logic [1:0] {
    SK_NONE = 2'd0,
    SK_DATA = 2'd1,
    SK_CAL  = 2'd2
  } slot_kind_e;

  // Decide what a converter slot does.
  function automatic slot_kind_e pick_slot(input logic slot, input logic fg,
                                           input logic full);
    if (!slot)            return SK_NONE;
    else if (fg || !full) return SK_CAL;
    else                  return SK_DATA;
  endfunction

  // A sample is accepted when the entry is free now or is freed this cycle.
  function automatic logic cap_ok(input logic samp, input logic fg,
                                  input logic full, input logic take);
    return samp & ~fg & (~full | take);
  endfunction

  // A sample is lost when the entry stays occupied through this cycle.
  function automatic logic ovr_hit(input logic samp, input logic fg,
                                   input logic full, input logic take);
    return samp & ~fg & full & ~take;
  endfunction

endpackage

// File: rtl/cqs_queue.sv
module cqs_queue
  import cqs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic samp_stb,
  input  logic fg_req,
  input  logic take,
  output logic full,
  output logic overrun
);

  logic full_q;
  logic ovr_q;
  logic cap_evt;
  logic drop_evt;

  assign cap_evt  = cap_ok(samp_stb, fg_req, full_q, take);
  assign drop_evt = ovr_hit(samp_stb, fg_req, full_q, take);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (fg_req) full_q <= 1'b0;
      else        full_q <= (full_q & ~take) | cap_evt;
      if (drop_evt) ovr_q <= 1'b1;
    end
  end

  assign full    = full_q;
  assign overrun = ovr_q;

  // R2: a taken entry is empty next cycle when nothing new arrives
  p_taken_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !samp_stb) |=> !full);

  // R4: an empty queue with a sample strobe holds it next cycle
  p_empty_captures_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_stb && !fg_req && !full) |=> full);

  // R5: the loss flag never falls once raised
  p_overrun_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  // R6: foreground flushes the entry and never flags a loss
  p_fg_flush_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fg_req |=> !full);
  p_fg_no_loss_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fg_req && !overrun) |=> !overrun);

endmodule

// File: rtl/cqs_arb.sv
module cqs_arb
  import cqs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       slot_stb,
  input  logic       fg_req,
  input  logic       full,
  output logic       take,
  output logic       cal,
  output slot_kind_e kind
);

  assign kind = pick_slot(slot_stb, fg_req, full);
  assign take = (kind == SK_DATA);
  assign cal  = (kind == SK_CAL);

  // R2: a take only happens with a held sample
  p_take_has_sample_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> full);

  // R3: at most one action per cycle, and every slot gets one
  p_one_action_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({take, cal}));
  p_slot_served_r3: assert property (@(posedge clk) disable iff (!rst_n)
    slot_stb |-> (take || cal));

  // R6: foreground never takes input
  p_fg_no_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fg_req |-> !take);

endmodule

// File: rtl/cqs_tagpipe.sv
module cqs_tagpipe
  import cqs_pkg::*;
#(
  parameter int LAT = 3,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  slot_kind_e    kind_in,
  input  logic [DW-1:0] res_in,
  output logic          dat_valid,
  output logic [DW-1:0] dat_out,
  output logic          cal_valid,
  output logic [DW-1:0] cal_out
);

  localparam int LAST = LAT - 1;

  for (genvar g = 0; g < LAT; g++) begin : g_st
    slot_kind_e q;
    if (g == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rst_n) q <= SK_NONE;
        else        q <= kind_in;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (!rst_n) q <= SK_NONE;
        else        q <= g_st[g-1].q;
      end
    end
  end

  slot_kind_e tail;
  assign tail      = g_st[LAST].q;
  assign dat_valid = (tail == SK_DATA);
  assign cal_valid = (tail == SK_CAL);
  assign dat_out   = dat_valid ? res_in : '0;
  assign cal_out   = cal_valid ? res_in : '0;

  // R7: a result belongs to exactly one stream
  p_out_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dat_valid, cal_valid}));

endmodule

// File: rtl/cal_queue_sched.sv
module cal_queue_sched
  import cqs_pkg::*;
#(
  parameter int DW  = 8,
  parameter int LAT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          samp_stb,
  input  logic          slot_stb,
  input  logic          fg_req,
  input  logic [DW-1:0] res_in,
  output logic          slot_take,
  output logic          slot_cal,
  output logic          q_full,
  output logic          err_overrun,
  output logic          dat_valid,
  output logic [DW-1:0] dat_out,
  output logic          cal_valid,
  output logic [DW-1:0] cal_out
);

  slot_kind_e kind;
  logic       take_w;
  logic       cal_w;
  logic       full_w;
  logic       ovr_w;

  cqs_queue u_queue (
    .clk      (clk),
    .rst_n    (rst_n),
    .samp_stb (samp_stb),
    .fg_req   (fg_req),
    .take     (take_w),
    .full     (full_w),
    .overrun  (ovr_w)
  );

  cqs_arb u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .slot_stb (slot_stb),
    .fg_req   (fg_req),
    .full     (full_w),
    .take     (take_w),
    .cal      (cal_w),
    .kind     (kind)
  );

  cqs_tagpipe #(.LAT(LAT), .DW(DW)) u_pipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .kind_in   (kind),
    .res_in    (res_in),
    .dat_valid (dat_valid),
    .dat_out   (dat_out),
    .cal_valid (cal_valid),
    .cal_out   (cal_out)
  );

  assign slot_take   = take_w;
  assign slot_cal    = cal_w;
  assign q_full      = full_w;
  assign err_overrun = ovr_w;

endmodule

// File: tb/sim_cal_queue_sched.sv
`timescale 1ns/1ps
module sim_cal_queue_sched;

  localparam int DW  = 8;
  localparam int LAT = 3;
  localparam int HN  = 4096;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic samp = 1'b0, slot = 1'b0, fg = 1'b0;
  logic [DW-1:0] res_in = '0;
  logic slot_take, slot_cal, q_full, err_overrun, dat_valid, cal_valid;
  logic [DW-1:0] dat_out, cal_out;

  int checks = 0, failures = 0;
  int cyc = 0;
  int hist [HN];
  bit mfull = 0, movr = 0;
  int n_dat = 0, n_cal = 0, n_take = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cal_queue_sched #(.DW(DW), .LAT(LAT)) u0 (
    .clk(clk), .rst_n(rst_n), .samp_stb(samp), .slot_stb(slot), .fg_req(fg),
    .res_in(res_in), .slot_take(slot_take), .slot_cal(slot_cal),
    .q_full(q_full), .err_overrun(err_overrun), .dat_valid(dat_valid),
    .dat_out(dat_out), .cal_valid(cal_valid), .cal_out(cal_out));

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", what, act, exp, cyc);
    end
  endtask

  task automatic clear_counts();
    n_dat = 0; n_cal = 0; n_take = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; samp = 0; slot = 0; fg = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    mfull = 0; movr = 0; cyc = 0;
    for (int i = 0; i < HN; i++) hist[i] = 0;
    #1;
    chk(q_full == 1'b0, "R1 q_full after reset", int'(q_full), 0);
    chk(err_overrun == 1'b0, "R1 err_overrun after reset", int'(err_overrun), 0);
    chk(dat_valid == 1'b0 && dat_out == '0, "R1 data output after reset", int'(dat_valid), 0);
    chk(cal_valid == 1'b0 && cal_out == '0, "R1 cal output after reset", int'(cal_valid), 0);
  endtask

  // One cycle: drive, check against the bench model, advance the model.
  task automatic step(input bit s, input bit k, input bit f);
    bit et, ec, cap, ov;
    int prev;
    logic [DW-1:0] exp_d, exp_c;
    @(negedge clk);
    samp = s; slot = k; fg = f;
    res_in = DW'((cyc * 37 + 11) & 255);
    #1;
    et = k && !f && mfull;
    ec = k && (f || !mfull);
    chk(q_full == mfull, "R4 queue occupancy", int'(q_full), int'(mfull));
    chk(err_overrun == movr, "R5 overrun flag", int'(err_overrun), int'(movr));
    chk(slot_take == et, "R2 take decision", int'(slot_take), int'(et));
    chk(slot_cal == ec, "R3 calibration decision", int'(slot_cal), int'(ec));
    if (f) chk(slot_take == 1'b0, "R6 no take in foreground", int'(slot_take), 0);
    prev = (cyc >= LAT) ? hist[(cyc - LAT) % HN] : 0;
    exp_d = (prev == 1) ? res_in : '0;
    exp_c = (prev == 2) ? res_in : '0;
    chk(dat_valid == (prev == 1), "R7 data valid timing", int'(dat_valid), int'(prev == 1));
    chk(cal_valid == (prev == 2), "R7 cal valid timing", int'(cal_valid), int'(prev == 2));
    chk(dat_out == exp_d, "R7 data routing", int'(dat_out), int'(exp_d));
    chk(cal_out == exp_c, "R7 cal routing", int'(cal_out), int'(exp_c));
    if (dat_valid) n_dat++;
    if (cal_valid) n_cal++;
    if (slot_take) n_take++;
    hist[cyc % HN] = et ? 1 : (ec ? 2 : 0);
    cap = s && !f && (!mfull || et);
    ov  = s && !f && mfull && !et;
    if (f) mfull = 0;
    else   mfull = (mfull && !et) || cap;
    if (ov) movr = 1;
    cyc++;
    @(posedge clk);
    #1;
  endtask

  task automatic drain();
    repeat (LAT + 2) step(0, 0, 0);
  endtask

  initial begin : main
    int ns, nk, t0;
    // ---------- R1 reset, R4/R5 directed ----------
    do_reset();
    step(1, 0, 0);
    chk(q_full == 1'b1, "R4 capture into empty queue", int'(q_full), 1);
    step(0, 0, 0);
    step(1, 0, 0);
    chk(err_overrun == 1'b1, "R5 overrun raised on dropped sample", int'(err_overrun), 1);
    step(0, 1, 0);
    chk(q_full == 1'b0, "R2 queue empty after take", int'(q_full), 0);
    step(0, 1, 0);
    step(0, 0, 0);
    chk(err_overrun == 1'b1, "R5 overrun stays set", int'(err_overrun), 1);
    drain();
    chk(n_dat == 1, "R5 only the held sample was converted", n_dat, 1);
    chk(n_cal == 1, "R5 second slot found the queue empty", n_cal, 1);

    do_reset();
    step(1, 0, 0);
    step(1, 1, 0);
    chk(q_full == 1'b1, "R4 take and capture in same cycle", int'(q_full), 1);
    chk(err_overrun == 1'b0, "R4 no overrun on same-cycle refill", int'(err_overrun), 0);
    step(0, 1, 0);
    drain();

    // ---------- R8 ratio 2 ----------
    do_reset(); clear_counts(); ns = 0; nk = 0;
    for (int c = 0; c < 400; c++) begin
      step((c % 4) == 0, (c % 2) == 0, 0);
      if ((c % 4) == 0) ns++;
      if ((c % 2) == 0) nk++;
    end
    drain();
    chk(err_overrun == 1'b0, "R8 ratio 2 no overrun", int'(err_overrun), 0);
    chk(n_dat == ns, "R8 ratio 2 data results equal samples", n_dat, ns);
    chk(n_cal == nk - ns, "R8 ratio 2 calibration results", n_cal, nk - ns);

    // ---------- R8 ratio 1.5 ----------
    do_reset(); clear_counts(); ns = 0; nk = 0;
    for (int c = 0; c < 600; c++) begin
      step((c % 3) == 0, (c % 2) == 0, 0);
      if ((c % 3) == 0) ns++;
      if ((c % 2) == 0) nk++;
    end
    drain();
    chk(err_overrun == 1'b0, "R8 ratio 1.5 no overrun", int'(err_overrun), 0);
    chk(n_dat == ns, "R8 ratio 1.5 data results equal samples", n_dat, ns);
    chk(n_cal == nk - ns, "R8 ratio 1.5 calibration results", n_cal, nk - ns);

    // ---------- R9 equal rates, R6 foreground window ----------
    do_reset(); clear_counts();
    for (int c = 0; c < 80; c++) step((c % 2) == 0, (c % 2) == 0, 0);
    chk(n_take == 39, "R9 every slot after the first takes", n_take, 39);
    t0 = n_take;
    for (int c = 80; c < 120; c++) step((c % 2) == 0, (c % 2) == 0, 1);
    chk(n_take == t0, "R6 no takes during foreground", n_take, t0);
    chk(q_full == 1'b0, "R6 queue flushed in foreground", int'(q_full), 0);
    chk(err_overrun == 1'b0, "R6 ignored samples raise no overrun", int'(err_overrun), 0);
    for (int c = 120; c < 200; c++) step((c % 2) == 0, (c % 2) == 0, 0);
    drain();
    chk(n_take == 78, "R9 takes resume after foreground", n_take, 78);
    chk(n_dat == 78, "R9 data result total", n_dat, 78);
    chk(n_cal == 22, "R6 calibration result total", n_cal, 22);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule